// File: doc/BRIEF.md
# Interrupt Request Priority and Acknowledge Core

This block is the datapath that sits behind the register interface of an eight-line interrupt controller. It watches eight raw request pins and latches a pending request only when a pin goes from low to high. It ranks the pending requests and the lines in service by fixed priority, with line 7 the most urgent and line 0 the least. When a new request may interrupt the processor, it drives a one-cycle pulse on `irq_out`. The register block supplies the mask, the vector base, the auto-EOI flag, the master flag and the map of cascaded lines. It also forwards end-of-interrupt commands as strobes.

When the processor acknowledges, the block answers in the same cycle. It returns an 8-bit vector and a valid flag. When the line is wired to a cascaded slave, it instead sets a flag saying the slave must supply the vector. The accepted request moves from the pending set to the in-service set, unless auto-EOI is enabled. An end-of-interrupt releases an in-service line and at once re-checks the highest pending request. Both register sets are exposed so the register block can read them back.

Top module: `irq_prio_core`

## Requirements
- R1: A request bit is latched only on a low-to-high transition of its pin, compared with the pin level sampled on the previous clock; a pin held high latches nothing further. After reset the stored previous level is 0.
- R2: A rising pin whose `mask` bit is 1 leaves its `irr` bit unchanged.
- R3: An unmasked rising pin sets `irr[line]` on the next clock edge.
- R4: `irq_out` is high for exactly the cycle after an unmasked rising edge on line L, and only if `isr` has no bit set at position L or above in the cycle of the edge.
- R5: An acknowledge with `irr` nonzero clears the highest-numbered set `irr` bit. If `auto_eoi` is 0 it also sets that line's `isr` bit; otherwise `isr` is left as it was.
- R6: `vec_valid` equals `ack_strobe` in the same cycle. For a real request, `vec_data` = (`vec_base` AND 0xF8) OR line number. With no acknowledge, `vec_data` and `vec_from_slave` are 0.
- R7: When `is_master` is 1 and `cascade_map[line]` is 1 for the acknowledged line, `vec_from_slave` is 1 in the acknowledge cycle.
- R8: An EOI with `eoi_specific`=1 clears `isr[eoi_line]`. With `eoi_specific`=0 it clears the highest set `isr` bit, and does nothing if `isr` is 0.
- R9: After an EOI (explicit, or implied by an auto-EOI acknowledge), if requests remain pending, `irq_out` pulses the next cycle. This happens when no remaining `isr` bit sits at or above the highest pending line.
- R10: An acknowledge while `irr` is 0 returns `vec_base` OR 0x07 with `vec_from_slave`=0, and changes neither `irr` nor `isr`.
- R11: Synchronous reset clears `irr`, `isr`, `irq_out` and the stored pin levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pins | input | 8 | Raw request pins, one per line |
| mask | input | 8 | Per-line mask, 1 blocks new requests |
| vec_base | input | 8 | Vector base; low three bits replaced by line |
| auto_eoi | input | 1 | Acknowledge performs the EOI itself |
| is_master | input | 1 | This controller is the master of a cascade |
| cascade_map | input | 8 | Lines that carry a cascaded slave |
| eoi_strobe | input | 1 | End-of-interrupt command this cycle |
| eoi_specific | input | 1 | 1: EOI names a line; 0: highest in service |
| eoi_line | input | 3 | Line released by a specific EOI |
| ack_strobe | input | 1 | Processor acknowledge |
| irq_out | output | 1 | One-cycle interrupt request pulse |
| vec_valid | output | 1 | Acknowledge response valid |
| vec_from_slave | output | 1 | Vector must be fetched from the slave |
| vec_data | output | 8 | Returned vector |
| irr | output | 8 | Pending request register |
| isr | output | 8 | In-service register |

## Verification
The assertions assume that reset is held from time zero until the first clock edges have passed. They also assume that `mask` and the pins are sampled as ordinary synchronous inputs. The in-service property further assumes that an acknowledge and an EOI naming the same line do not arrive together. The directed part of the stimulus applies at most one command per cycle. The random phase keeps EOIs and acknowledges sparse and independent. The assertion premises exclude the cycles where both meet, so the cycle-level reference model alone judges those collisions.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;
    localparam int IRQ_LINES = 8;
    localparam int LINE_W    = $clog2(IRQ_LINES);
    localparam int VEC_W     = 8;

    typedef logic [IRQ_LINES-1:0] line_vec_t;
    typedef logic [LINE_W-1:0]    line_idx_t;

    typedef struct packed {
        logic             valid;
        logic             from_slave;
        logic [VEC_W-1:0] vector;
    } ack_resp_t;

    // index of the highest set bit, 0 when empty
    function automatic line_idx_t top_line(input line_vec_t v);
        line_idx_t r;
        r = '0;
        for (int i = 0; i < IRQ_LINES; i++)
            if (v[i]) r = line_idx_t'(i);
        return r;
    endfunction

    // true when nothing is in service at level l or higher
    function automatic logic free_from(input line_vec_t svc, input line_idx_t l);
        return (svc >> l) == '0;
    endfunction

    function automatic line_vec_t bit_of(input line_idx_t l);
        return line_vec_t'(1) << l;
    endfunction
endpackage

// File: rtl/irq_edge_capture.sv
module irq_edge_capture
    import irq_core_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t pins,
    input  line_vec_t mask,
    output line_vec_t new_req
);
    line_vec_t last_lvl;

    always_ff @(posedge clk) begin
        if (rst) last_lvl <= '0;
        else     last_lvl <= pins;
    end

    assign new_req = pins & ~last_lvl & ~mask;
endmodule

// File: rtl/irq_ack_path.sv
module irq_ack_path
    import irq_core_pkg::*;
(
    input  logic             ack_strobe,
    input  line_vec_t        irr_q,
    input  logic [VEC_W-1:0] vec_base,
    input  logic             auto_eoi,
    input  logic             is_master,
    input  line_vec_t        cascade_map,
    output ack_resp_t        resp,
    output line_vec_t        ack_clr,
    output line_vec_t        svc_set,
    output logic             auto_done
);
    localparam logic [VEC_W-1:0] LOW_MASK = VEC_W'((1 << LINE_W) - 1);

    logic      real_req;
    line_idx_t sel;

    always_comb begin
        real_req  = ack_strobe && (irr_q != '0);
        sel       = top_line(irr_q);
        resp      = '0;
        ack_clr   = '0;
        svc_set   = '0;
        auto_done = 1'b0;
        if (ack_strobe) begin
            resp.valid = 1'b1;
            if (real_req) begin
                resp.vector     = (vec_base & ~LOW_MASK) | VEC_W'(sel);
                resp.from_slave = is_master && cascade_map[sel];
                ack_clr         = bit_of(sel);
                if (auto_eoi) auto_done = 1'b1;
                else          svc_set   = bit_of(sel);
            end else begin
                resp.vector = vec_base | LOW_MASK;
            end
        end
    end
endmodule

// File: rtl/irq_eoi_decode.sv
module irq_eoi_decode
    import irq_core_pkg::*;
(
    input  logic      eoi_strobe,
    input  logic      eoi_specific,
    input  line_idx_t eoi_line,
    input  line_vec_t isr_q,
    output line_vec_t eoi_clr,
    output logic      eoi_done
);
    always_comb begin
        eoi_clr  = '0;
        eoi_done = 1'b0;
        if (eoi_strobe) begin
            if (eoi_specific) begin
                eoi_clr  = bit_of(eoi_line);
                eoi_done = 1'b1;
            end else if (isr_q != '0) begin
                eoi_clr  = bit_of(top_line(isr_q));
                eoi_done = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
    import irq_core_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IRQ_LINES-1:0] irq_pins,
    input  logic [IRQ_LINES-1:0] mask,
    input  logic [VEC_W-1:0]     vec_base,
    input  logic                 auto_eoi,
    input  logic                 is_master,
    input  logic [IRQ_LINES-1:0] cascade_map,
    input  logic                 eoi_strobe,
    input  logic                 eoi_specific,
    input  logic [LINE_W-1:0]    eoi_line,
    input  logic                 ack_strobe,
    output logic                 irq_out,
    output logic                 vec_valid,
    output logic                 vec_from_slave,
    output logic [VEC_W-1:0]     vec_data,
    output logic [IRQ_LINES-1:0] irr,
    output logic [IRQ_LINES-1:0] isr
);
    line_vec_t irr_q, isr_q, new_req, ack_clr, svc_set, eoi_clr;
    line_vec_t irr_left, isr_left;
    ack_resp_t resp;
    logic      auto_done, eoi_done, edge_ok, reeval_ok, pulse_q;

    irq_edge_capture u_edge (
        .clk(clk), .rst(rst), .pins(irq_pins), .mask(mask), .new_req(new_req)
    );

    irq_ack_path u_ack (
        .ack_strobe(ack_strobe), .irr_q(irr_q), .vec_base(vec_base),
        .auto_eoi(auto_eoi), .is_master(is_master), .cascade_map(cascade_map),
        .resp(resp), .ack_clr(ack_clr), .svc_set(svc_set), .auto_done(auto_done)
    );

    irq_eoi_decode u_eoi (
        .eoi_strobe(eoi_strobe), .eoi_specific(eoi_specific),
        .eoi_line(eoi_line), .isr_q(isr_q),
        .eoi_clr(eoi_clr), .eoi_done(eoi_done)
    );

    always_comb begin
        irr_left = irr_q & ~ack_clr;
        isr_left = isr_q & ~eoi_clr;
        edge_ok  = 1'b0;
        for (int i = 0; i < IRQ_LINES; i++)
            if (new_req[i] && free_from(isr_q, line_idx_t'(i))) edge_ok = 1'b1;
        reeval_ok = (eoi_done || auto_done) && (irr_left != '0)
                    && free_from(isr_left, top_line(irr_left));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q   <= '0;
            isr_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            irr_q   <= irr_left | new_req;
            isr_q   <= isr_left | svc_set;
            pulse_q <= edge_ok || reeval_ok;
        end
    end

    assign irq_out        = pulse_q;
    assign vec_valid      = resp.valid;
    assign vec_from_slave = resp.from_slave;
    assign vec_data       = resp.vector;
    assign irr            = irr_q;
    assign isr            = isr_q;
endmodule

// File: rtl/irq_prio_core_chk.sv
module irq_prio_core_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] irq_pins,
    input logic [7:0] mask,
    input logic [7:0] vec_base,
    input logic       auto_eoi,
    input logic       eoi_strobe,
    input logic       eoi_specific,
    input logic [2:0] eoi_line,
    input logic       ack_strobe,
    input logic       vec_valid,
    input logic       vec_from_slave,
    input logic [7:0] vec_data,
    input logic [7:0] irr,
    input logic [7:0] isr
);
    // R1
    edge_needs_pin_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((irr & ~$past(irr) & ~$past(irq_pins)) == 8'h00));

    // R2
    masked_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((irr & ~$past(irr) & $past(mask)) == 8'h00));

    // R5
    ack_to_service_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_strobe && irr != 8'h00 && !auto_eoi && !eoi_strobe)
        |=> isr[$past(vec_data[2:0])]);

    // R6
    valid_follows_ack_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid == ack_strobe);

    // R6
    picks_highest_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_strobe && irr != 8'h00) |-> ((irr >> vec_data[2:0]) == 8'h01));

    // R8
    specific_eoi_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_strobe && eoi_specific && !ack_strobe) |=> !isr[$past(eoi_line)]);

    // R10
    spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_strobe && irr == 8'h00)
        |-> (vec_data == (vec_base | 8'h07) && !vec_from_slave));
endmodule

bind irq_prio_core irq_prio_core_chk chk_i (
    .clk(clk), .rst(rst), .irq_pins(irq_pins), .mask(mask), .vec_base(vec_base),
    .auto_eoi(auto_eoi), .eoi_strobe(eoi_strobe), .eoi_specific(eoi_specific),
    .eoi_line(eoi_line), .ack_strobe(ack_strobe), .vec_valid(vec_valid),
    .vec_from_slave(vec_from_slave), .vec_data(vec_data), .irr(irr), .isr(isr)
);

// File: tb/irq_prio_core_tb.sv
module irq_prio_core_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_pins = '0, mask = '0, vec_base = '0, cascade_map = '0;
    logic       auto_eoi = 0, is_master = 0, eoi_strobe = 0, eoi_specific = 0, ack_strobe = 0;
    logic [2:0] eoi_line = '0;
    logic       irq_out, vec_valid, vec_from_slave;
    logic [7:0] vec_data, irr, isr;

    int n_checks = 0, n_fail = 0;

    // reference state
    bit [7:0] m_prev = 0, m_irr = 0, m_isr = 0;
    bit       m_pulse = 0;

    always #10 clk = ~clk;

    irq_prio_core dut_i (
        .clk(clk), .rst(rst), .irq_pins(irq_pins), .mask(mask), .vec_base(vec_base),
        .auto_eoi(auto_eoi), .is_master(is_master), .cascade_map(cascade_map),
        .eoi_strobe(eoi_strobe), .eoi_specific(eoi_specific), .eoi_line(eoi_line),
        .ack_strobe(ack_strobe), .irq_out(irq_out), .vec_valid(vec_valid),
        .vec_from_slave(vec_from_slave), .vec_data(vec_data), .irr(irr), .isr(isr)
    );

    function automatic int highest(bit [7:0] v);
        int h = -1;
        for (int i = 0; i < 8; i++) if (v[i]) h = i;
        return h;
    endfunction

    function automatic bit nothing_above(bit [7:0] s, int l);
        for (int i = l; i < 8; i++) if (s[i]) return 0;
        return 1;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: compare at mid-low phase, then advance the model
    task automatic step();
        bit [7:0] rise, irr_left, isr_left, n_irr, n_isr;
        bit       ev, n_pulse, e_valid, e_slave;
        int       sel, e_vec;
        #5;
        sel = highest(m_irr);
        e_valid = ack_strobe;
        e_slave = 0;
        e_vec = 0;
        if (ack_strobe) begin
            if (sel < 0) e_vec = vec_base | 8'h07;
            else begin
                e_vec = (vec_base & 8'hF8) | sel;
                e_slave = is_master && cascade_map[sel];
            end
        end
        check("R4/R9", "irq_out", irq_out, m_pulse);
        check("R1/R3/R5", "irr", irr, m_irr);
        check("R5/R8", "isr", isr, m_isr);
        check("R6", "vec_valid", vec_valid, e_valid);
        check("R6/R10", "vec_data", vec_data, e_vec);
        check("R7", "vec_from_slave", vec_from_slave, e_slave);

        rise = irq_pins & ~m_prev & ~mask;
        irr_left = m_irr;
        isr_left = m_isr;
        ev = 0;
        if (ack_strobe && sel >= 0) begin
            irr_left[sel] = 0;
            if (auto_eoi) ev = 1;
        end
        if (eoi_strobe) begin
            if (eoi_specific) begin isr_left[eoi_line] = 0; ev = 1; end
            else if (m_isr != 0) begin isr_left[highest(m_isr)] = 0; ev = 1; end
        end
        n_pulse = 0;
        for (int i = 0; i < 8; i++)
            if (rise[i] && nothing_above(m_isr, i)) n_pulse = 1;
        if (ev && irr_left != 0 && nothing_above(isr_left, highest(irr_left))) n_pulse = 1;
        n_irr = irr_left | rise;
        n_isr = isr_left;
        if (ack_strobe && sel >= 0 && !auto_eoi) n_isr[sel] = 1;
        @(posedge clk);
        if (rst) begin m_prev = 0; m_irr = 0; m_isr = 0; m_pulse = 0; end
        else begin m_prev = irq_pins; m_irr = n_irr; m_isr = n_isr; m_pulse = n_pulse; end
        @(negedge clk);
        ack_strobe = 0;
        eoi_strobe = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic ack1();
        ack_strobe = 1; step();
    endtask

    task automatic eoi1(bit spec, int line);
        eoi_strobe = 1; eoi_specific = spec; eoi_line = 3'(line); step();
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        idle(3);                          // R11 reset state compared in step
        rst = 0;
        vec_base = 8'h20;
        idle(1);
        irq_pins[3] = 1; idle(3);         // R3 R4 pulse after edge
        idle(3);                          // R1 held pin adds nothing
        mask = 8'h10; irq_pins[4] = 1; idle(2);  // R2 masked edge
        irq_pins[4] = 0; mask = 0; idle(1);
        irq_pins[5] = 1; idle(2);
        ack1();                           // R5 R6 picks line 5
        irq_pins[6] = 1; idle(2);         // R4 above in-service -> pulse
        irq_pins[2] = 1; idle(2);         // R4 blocked by line 5
        ack1();                           // line 6 into service
        eoi1(1, 6);                       // R8 R9 blocked by 5
        idle(1);
        eoi1(0, 0);                       // R8 nonspecific clears 5, R9 pulse
        idle(1);
        ack1(); ack1(); idle(1);          // lines 3 and 2
        ack1();                           // R10 spurious
        eoi1(0, 0); eoi1(0, 0); eoi1(0, 0); // last one with empty isr
        irq_pins = 0; idle(1);
        auto_eoi = 1;
        irq_pins[7] = 1; irq_pins[1] = 1; idle(2);
        ack1();                           // R5 auto-EOI, R9 re-issue for 1
        idle(1); ack1(); idle(1);
        auto_eoi = 0; irq_pins = 0; idle(1);
        is_master = 1; cascade_map = 8'h04; vec_base = 8'h48;
        irq_pins[2] = 1; idle(2);
        ack1();                           // R7 slave supplies vector
        eoi1(1, 2);
        irq_pins = 0; idle(1);
        is_master = 0; irq_pins[2] = 1; idle(2);
        ack1();                           // R7 not master -> local vector
        eoi1(1, 2);
        for (int k = 0; k < 600; k++) begin
            irq_pins = 8'($urandom);
            mask = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
            auto_eoi = ($urandom % 8 == 0);
            is_master = $urandom % 2;
            cascade_map = 8'($urandom);
            vec_base = 8'($urandom);
            ack_strobe = ($urandom % 4 == 0);
            eoi_strobe = ($urandom % 4 == 0);
            eoi_specific = $urandom % 2;
            eoi_line = 3'($urandom);
            step();
        end
        rst = 1; idle(2);                 // R11 reset mid-run
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule